// File: doc/BRIEF.md
# Synchronous Processor Bus Slave Interface

This block lets on-chip user logic appear as a small memory-mapped peripheral on an external synchronous microprocessor bus. The bus has separate address and data lines, a read/write line, an active-low transfer-start strobe, and two chip selects of opposite polarity. The block answers each single-beat transfer with a one-cycle active-low acknowledge. It asserts the active-low burst-inhibit line in that same cycle, so the processor never starts a burst.

Writes go into a parameterised register file. Reads return a register value, or the contents of a read-only status register at the top of the address space. A level interrupt request from user logic is passed to the processor on an active-low interrupt pin. The same request can also be polled through bit 0 of the status register. The shared data pins are modelled as a separate input, output and output enable.

Top module: `proc_bus_slave`

## Requirements
- R1: The port is selected only while `cs_n` is 0 and `cs` is 1. A strobe on `ts_n` while the port is not selected causes no acknowledge, no burst-inhibit, no data drive and no register write.
- R2: After `ts_n` is sampled low on a clock edge while the port is selected, `ta_n` is low for exactly the next clock cycle.
- R3: `bi_n` is low in exactly the cycles where `ta_n` is low, and high at all other times.
- R4: In a selected write (`rw` = 0), the value on `dat_in` at the clock edge that ends the acknowledge cycle is stored in register `addr`, for addresses 0 to DEPTH-1.
- R5: In a selected read (`rw` = 1), `dat_out` holds the addressed value and `dat_oe` is 1 during the acknowledge cycle. At all other times `dat_oe` is 0.
- R6: After reset, all registers read 0, `ta_n`, `bi_n` and `irq_n` are 1, and `dat_oe` is 0.
- R7: `irq_n` goes low one clock edge after `usr_irq` rises. It stays low as long as `usr_irq` stays high, whatever bus traffic occurs, and goes high one clock edge after `usr_irq` falls.
- R8: Address 2^AW-1 (31 by default) is a status register. It reads with bit 0 equal to the registered interrupt request and all other bits 0. Writes to it have no effect.
- R9: Addresses from DEPTH up to 2^AW-2 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Register address |
| rw | input | 1 | 1 = read, 0 = write |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| ts_n | input | 1 | Active-low transfer-start strobe |
| dat_in | input | DW | Write data from the bus |
| dat_out | output | DW | Read data to the bus |
| dat_oe | output | 1 | Data pin output enable |
| ta_n | output | 1 | Active-low transfer acknowledge |
| bi_n | output | 1 | Active-low burst inhibit |
| usr_irq | input | 1 | Interrupt request from user logic |
| irq_n | output | 1 | Active-low interrupt to the processor |

## Verification
The register file is written and read back with several data patterns: an address-dependent sequence, walking ones, and the all-ones and all-zeros values. Together these expose swapped, stuck or aliased data bits and address bits. Transfers are also tried under each of the three deselected chip-select combinations, which separates a correct AND of both selects from a decode that checks only one of them. Out-of-range addresses and writes to the status register show whether writes are kept out of unmapped and read-only locations. Raising and dropping the interrupt request with reads in between checks that the pin and the status bit follow the request and not the bus.

// File: rtl/psb_pkg.sv
package psb_pkg;
   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;

   localparam int STAT_IRQ_BIT = 0;
endpackage

// File: rtl/psb_bus_fsm.sv
module psb_bus_fsm
   import psb_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          rw,
   input  logic          cs_n,
   input  logic          cs,
   input  logic          ts_n,
   input  logic [DW-1:0] rd_val,
   output logic [DW-1:0] rdata,
   output logic          data_oe,
   output logic          ta_n,
   output logic          bi_n,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr
);
   logic      sel;
   logic      start;
   xfer_dir_e dir;
   logic      ack_q;
   logic      inh_q;
   logic      oe_q;
   logic      wr_q;

   assign sel   = !cs_n && cs;
   assign start = !ts_n && sel;
   assign dir   = xfer_dir_e'(rw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         inh_q   <= 1'b0;
         oe_q    <= 1'b0;
         wr_q    <= 1'b0;
         wr_addr <= '0;
         rdata   <= '0;
      end else begin
         ack_q <= start;
         inh_q <= start;
         oe_q  <= start && (dir == XFER_READ);
         wr_q  <= start && (dir == XFER_WRITE);
         if (start) wr_addr <= addr;
         if (start && (dir == XFER_READ)) rdata <= rd_val;
      end
   end

   assign ta_n    = !ack_q;
   assign bi_n    = !inh_q;
   assign data_oe = oe_q;
   assign wr_en   = wr_q;

   p_ack_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ts_n && !cs_n && cs) |=> !ta_n);
   p_no_ack_unselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ts_n && !(!cs_n && cs)) |=> (ta_n && bi_n && !data_oe));
   p_bi_with_ta_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ta_n == bi_n));
   p_oe_only_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> !ta_n);
   p_wr_only_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!ta_n && !data_oe));
endmodule

// File: rtl/psb_regfile.sv
module psb_regfile #(
   parameter int AW    = 5,
   parameter int DW    = 8,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   input  logic          irq_bit,
   output logic [DW-1:0] rdata
);
   localparam logic [AW-1:0] STATUS_ADDR = {AW{1'b1}};

   logic [DW-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem[i] <= '0;
         else if (we && (waddr == AW'(i)))      mem[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (raddr == STATUS_ADDR) begin
         rdata[psb_pkg::STAT_IRQ_BIT] = irq_bit;
      end else begin
         for (int j = 0; j < DEPTH; j++) begin
            if (raddr == AW'(j)) rdata = mem[j];
         end
      end
   end

   p_status_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (raddr == STATUS_ADDR) |-> (rdata >> 1) == '0);
endmodule

// File: rtl/psb_irq.sv
module psb_irq #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic irq_n,
   output logic stat
);
   if (IRQ_REG) begin : g_reg
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= req;
      end
      assign stat  = req_q;
      assign irq_n = !req_q;

      p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
         req |=> !irq_n);
      p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !req |=> irq_n);
   end else begin : g_comb
      assign stat  = req;
      assign irq_n = !req;
   end
endmodule

// File: rtl/proc_bus_slave.sv
module proc_bus_slave #(
   parameter int AW      = 5,
   parameter int DW      = 8,
   parameter int DEPTH   = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          rw,
   input  logic          cs_n,
   input  logic          cs,
   input  logic          ts_n,
   input  logic [DW-1:0] dat_in,
   output logic [DW-1:0] dat_out,
   output logic          dat_oe,
   output logic          ta_n,
   output logic          bi_n,
   input  logic          usr_irq,
   output logic          irq_n
);
   if (AW < 2)              begin : g_bad_aw    $error("AW must be at least 2");       end
   if (DW < 1)              begin : g_bad_dw    $error("DW must be at least 1");       end
   if (DEPTH < 1)           begin : g_bad_depth $error("DEPTH must be at least 1");    end
   if (DEPTH >= (1 << AW))  begin : g_bad_map   $error("DEPTH overlaps status slot");  end

   logic [DW-1:0] rd_val;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic          irq_stat;

   psb_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .rw      (rw),
      .cs_n    (cs_n),
      .cs      (cs),
      .ts_n    (ts_n),
      .rd_val  (rd_val),
      .rdata   (dat_out),
      .data_oe (dat_oe),
      .ta_n    (ta_n),
      .bi_n    (bi_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr)
   );

   psb_regfile #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (wr_addr),
      .wdata   (dat_in),
      .raddr   (addr),
      .irq_bit (irq_stat),
      .rdata   (rd_val)
   );

   psb_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (usr_irq),
      .irq_n (irq_n),
      .stat  (irq_stat)
   );

   p_reset_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ta_n && bi_n && !dat_oe));
endmodule

// File: tb/tb_proc_bus_slave.sv
module tb_proc_bus_slave;
   localparam int CLK_P = 10;
   localparam int AW    = 5;
   localparam int DW    = 8;
   localparam int DEPTH = 8;
   localparam logic [AW-1:0] STAT_A = {AW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          rw = 1'b1;
   logic          cs_n = 1'b1;
   logic          cs = 1'b0;
   logic          ts_n = 1'b1;
   logic [DW-1:0] dat_in = '0;
   logic [DW-1:0] dat_out;
   logic          dat_oe;
   logic          ta_n;
   logic          bi_n;
   logic          usr_irq = 1'b0;
   logic          irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   always #(CLK_P/2) clk = ~clk;

   proc_bus_slave #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .cs_n(cs_n), .cs(cs),
      .ts_n(ts_n), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
      .ta_n(ta_n), .bi_n(bi_n), .usr_irq(usr_irq), .irq_n(irq_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Monitor: pops expected read data whenever the design drives the bus
   always @(negedge clk) begin
      if (rst_n && dat_oe) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected drive", int'(dat_out), 0);
         end else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(dat_out == e, t, int'(dat_out), int'(e));
            chk(!ta_n, "R5 drive outside ack", int'(ta_n), 0);
         end
      end
   end

   // One bus transfer; sel_n/sel give the chip-select levels
   task automatic xfer(input logic sel_n, input logic sel, input logic dir,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] exp_rd, input string tag);
      automatic bit selected = !sel_n && sel;
      @(negedge clk);
      addr = a; rw = dir; cs_n = sel_n; cs = sel; ts_n = 1'b0;
      if (selected && dir) begin
         exp_q.push_back(exp_rd);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      ts_n = 1'b0 ^ 1'b1;
      dat_in = d;
      if (selected) begin
         chk(!ta_n, "R2 ack missing", int'(ta_n), 0);
         chk(!bi_n, "R3 bi with ack", int'(bi_n), 0);
      end else begin
         chk(ta_n && bi_n && !dat_oe, "R1 unselected strobe answered",
             int'({ta_n, bi_n, dat_oe}), 3'b110);
      end
      @(negedge clk);
      chk(ta_n, "R2 ack longer than one cycle", int'(ta_n), 1);
      chk(bi_n, "R3 bi longer than ack", int'(bi_n), 1);
      chk(!dat_oe, "R5 drive after ack", int'(dat_oe), 0);
      cs_n = 1'b1; cs = 1'b0;
      if (selected && !dir && a < DEPTH) model[a] = d;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      xfer(1'b0, 1'b1, 1'b0, a, d, '0, "R4");
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      xfer(1'b0, 1'b1, 1'b1, a, '0, e, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R6: reset state
      chk(ta_n && bi_n && irq_n && !dat_oe, "R6 reset outputs",
          int'({ta_n, bi_n, irq_n, dat_oe}), 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ta_n && bi_n && irq_n && !dat_oe, "R6 idle after reset",
          int'({ta_n, bi_n, irq_n, dat_oe}), 4'b1110);
      for (int i = 0; i < DEPTH; i++) rd(AW'(i), '0, "R6 reg reset value");

      // R4/R5: address-dependent pattern
      for (int i = 0; i < DEPTH; i++) wr(AW'(i), DW'(8'h11 * (i + 1)));
      for (int i = 0; i < DEPTH; i++) rd(AW'(i), model[i], "R5 pattern readback");
      // walking ones
      for (int i = 0; i < DEPTH; i++) wr(AW'(i), DW'(1) << (i % DW));
      for (int i = DEPTH - 1; i >= 0; i--) rd(AW'(i), model[i], "R4 walking ones");
      // extremes
      wr(AW'(0), 8'hFF); wr(AW'(DEPTH - 1), 8'h00);
      rd(AW'(0), 8'hFF, "R4 all ones"); rd(AW'(DEPTH - 1), 8'h00, "R4 all zeros");

      // R1: each deselected combination, write attempt then readback
      xfer(1'b1, 1'b1, 1'b0, AW'(2), 8'hA5, '0, "R1");
      xfer(1'b0, 1'b0, 1'b0, AW'(2), 8'hA5, '0, "R1");
      xfer(1'b1, 1'b0, 1'b0, AW'(2), 8'hA5, '0, "R1");
      xfer(1'b1, 1'b0, 1'b1, AW'(2), 8'h00, '0, "R1");
      rd(AW'(2), model[2], "R1 unselected write ignored");

      // R9: unmapped addresses
      wr(AW'(DEPTH), 8'h5A); wr(STAT_A - 1, 8'h3C);
      rd(AW'(DEPTH), 8'h00, "R9 unmapped reads zero");
      rd(STAT_A - 1, 8'h00, "R9 top unmapped reads zero");
      for (int i = 0; i < DEPTH; i++) rd(AW'(i), model[i], "R9 no aliasing");

      // R7/R8: interrupt path
      rd(STAT_A, 8'h00, "R8 status idle");
      @(negedge clk); usr_irq = 1'b1;
      @(negedge clk);
      chk(!irq_n, "R7 irq asserted", int'(irq_n), 0);
      rd(STAT_A, 8'h01, "R8 status shows irq");
      wr(STAT_A, 8'hFE);
      rd(STAT_A, 8'h01, "R8 status write ignored");
      chk(!irq_n, "R7 irq held across traffic", int'(irq_n), 0);
      @(negedge clk); usr_irq = 1'b0;
      @(negedge clk);
      chk(irq_n, "R7 irq released", int'(irq_n), 1);
      rd(STAT_A, 8'h00, "R8 status cleared");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 read never driven", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule